// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block keeps a small group of interrupt sources behind a 32-bit register-write port. Each source owns one bit of a status register. A source's bit is set by a hardware event pulse or by software through a trigger command, and software clears it by writing a one to that bit. A mask register decides which pending bits may reach the single level-sensitive interrupt line.

The mask cannot be written directly. Software unmasks sources through an enable command and masks them through a disable command. Both commands act only on the bit positions written as one. This lets independent drivers change their own sources without a read-modify-write sequence.

Reads are combinational from the registered state. Every register is `NUM_SRC` bits wide, 10 by default, and is zero-extended to 32 bits on read.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the status register is 0, the mask register is 0x3FF (every source masked) and `irq` is low.
- R2: A read at byte offset 0x00 returns the status and one at 0x04 returns the mask, with bits 31:10 zero. Reads of 0x08, 0x0C and 0x10, and of any unmapped offset, return zero.
- R3: A write to offset 0x00 clears every status bit written as one and leaves the bits written as zero unchanged.
- R4: A write to offset 0x04 has no effect on the mask. The mask changes only through the enable and disable commands.
- R5: Writing ones to the enable command at offset 0x08 clears the matching mask bits and leaves the other mask bits unchanged.
- R6: Writing ones to the disable command at offset 0x0C sets the matching mask bits and leaves the other mask bits unchanged.
- R7: Writing ones to the trigger command at offset 0x10 sets the matching status bits.
- R8: A high bit on `hw_event` sets the matching status bit. If that bit is cleared by software in the same cycle, the set wins.
- R9: `irq` equals the OR of (status AND NOT mask) and follows each status or mask change in the same cycle that the register changes.
- R10: Bits 31:10 of every write are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 5 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte offset of the combinational read |
| rd_data | output | 32 | Read data for `rd_addr` |
| hw_event | input | 10 | One-cycle set pulses from the interrupt sources |
| irq | output | 1 | Level interrupt request |

## Verification
A write or an event applied before a rising edge takes effect at that edge, in status, in mask and in `irq` together. Read data depends only on the registered state and `rd_addr`, so it is valid once that edge has passed.

The bench drives every input on the falling edge and holds it across one rising edge. It then removes the input and samples `irq` and `rd_data` at the following falling edge, with the read address stepped through each register. An exhaustive sweep over all 1024 enable patterns, each paired with a computed trigger pattern, compares the mask, the status and the interrupt line with values the bench computes arithmetically.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Byte offsets of the register group
    localparam int unsigned OFS_STATUS  = 'h00;
    localparam int unsigned OFS_MASK    = 'h04;
    localparam int unsigned OFS_UNMASK  = 'h08;
    localparam int unsigned OFS_SETMASK = 'h0C;
    localparam int unsigned OFS_FIRE    = 'h10;

    // One-hot write command decoded from a bus write
    typedef struct packed {
        logic clr_stat;   // write-one-to-clear status
        logic unmask;     // clear mask bits
        logic setmask;    // set mask bits
        logic fire;       // set status bits
    } cmd_t;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output cmd_t              cmd
);

    always_comb begin
        cmd          = '0;
        cmd.clr_stat = wr_en && (wr_addr == ADDR_W'(OFS_STATUS));
        cmd.unmask   = wr_en && (wr_addr == ADDR_W'(OFS_UNMASK));
        cmd.setmask  = wr_en && (wr_addr == ADDR_W'(OFS_SETMASK));
        cmd.fire     = wr_en && (wr_addr == ADDR_W'(OFS_FIRE));
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_t               cmd,
    input  logic [NUM_SRC-1:0] wr_bits,
    input  logic [NUM_SRC-1:0] hw_event,
    output logic [NUM_SRC-1:0] status_q,
    output logic [NUM_SRC-1:0] mask_q,
    output logic               irq_q
);

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] mask;
        logic               irq;
    } state_t;

    localparam state_t RESET_STATE = '{status: '0, mask: '1, irq: 1'b0};

    state_t st_d;
    state_t st_q;

    always_comb begin
        st_d = st_q;
        // status: clear by software, then any set source wins
        if (cmd.clr_stat) begin
            st_d.status = st_d.status & ~wr_bits;
        end
        if (cmd.fire) begin
            st_d.status = st_d.status | wr_bits;
        end
        st_d.status = st_d.status | hw_event;
        // mask: only through the two commands
        if (cmd.unmask) begin
            st_d.mask = st_d.mask & ~wr_bits;
        end
        if (cmd.setmask) begin
            st_d.mask = st_d.mask | wr_bits;
        end
        // output registered from the next state so it moves with the registers
        st_d.irq = |(st_d.status & ~st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q = st_q.status;
    assign mask_q   = st_q.mask;
    assign irq_q    = st_q.irq;

endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 10,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC-1:0] mask,
    output logic [DATA_W-1:0]  rd_data
);

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_STATUS)) begin
            rd_data = DATA_W'(status);
        end else if (rd_addr == ADDR_W'(OFS_MASK)) begin
            rd_data = DATA_W'(mask);
        end
    end

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 10,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] hw_event,
    output logic               irq
);

    cmd_t               cmd_w;
    logic [NUM_SRC-1:0] status_w;
    logic [NUM_SRC-1:0] mask_w;
    logic               unused_hi;

    // reserved write bits carry no state
    assign unused_hi = ^wr_data[DATA_W-1:NUM_SRC];

    irqc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .cmd     (cmd_w)
    );

    irqc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd_w),
        .wr_bits  (wr_data[NUM_SRC-1:0]),
        .hw_event (hw_event),
        .status_q (status_w),
        .mask_q   (mask_w),
        .irq_q    (irq)
    );

    irqc_rdmux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
        .rd_addr (rd_addr),
        .status  (status_w),
        .mask    (mask_w),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 10,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         wr_addr,
    input logic [NUM_SRC-1:0]        wr_low,
    input logic [NUM_SRC-1:0]        hw_event,
    input logic [NUM_SRC-1:0]        status,
    input logic [NUM_SRC-1:0]        mask,
    input logic                      irq,
    input logic [DATA_W-NUM_SRC-1:0] rd_hi
);

    logic is_clr, is_unm, is_set, is_fire;
    assign is_clr  = wr_en && (wr_addr == ADDR_W'(OFS_STATUS));
    assign is_unm  = wr_en && (wr_addr == ADDR_W'(OFS_UNMASK));
    assign is_set  = wr_en && (wr_addr == ADDR_W'(OFS_SETMASK));
    assign is_fire = wr_en && (wr_addr == ADDR_W'(OFS_FIRE));

    assert_rd_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi == '0);

    assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr |=> (status & $past(wr_low) & ~$past(hw_event)) == '0);

    assert_mask_only_by_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_unm || is_set) |=> $stable(mask));

    assert_unmask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_unm |=> (mask & $past(wr_low)) == '0);

    assert_setmask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_set |=> (mask & $past(wr_low)) == $past(wr_low));

    assert_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_fire |=> (status & $past(wr_low)) == $past(wr_low));

    assert_event_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_event) |=> (status & $past(hw_event)) == $past(hw_event));

    assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(status & ~mask));

endmodule

bind irq_mask_ctrl irqc_checker #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_irqc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_low   (wr_data[NUM_SRC-1:0]),
    .hw_event (hw_event),
    .status   (status_w),
    .mask     (mask_w),
    .irq      (irq),
    .rd_hi    (rd_data[DATA_W-1:NUM_SRC])
);

// File: tb/test_irq_mask_ctrl.sv
module test_irq_mask_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [N-1:0] hw_event = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] m_status;
    logic [N-1:0] m_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_mask_ctrl i_irq_mask_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .hw_event (hw_event),
        .irq      (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // Apply one cycle of stimulus and update the bench model per R3 R5 R6 R7 R8
    task automatic op(input logic en, input logic [4:0] a, input logic [31:0] d,
                      input logic [N-1:0] ev);
        logic [N-1:0] b;
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d; hw_event = ev;
        b = d[N-1:0];
        if (en) begin
            case (a)
                5'h00: m_status = m_status & ~b;
                5'h08: m_mask   = m_mask & ~b;
                5'h0C: m_mask   = m_mask | b;
                5'h10: m_status = m_status | b;
                default: ;
            endcase
        end
        m_status = m_status | ev;
        @(negedge clk);
        wr_en = 1'b0; hw_event = '0; wr_data = '0;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        rd(5'h00, v); chk({req, " status"}, v, 32'(m_status));
        rd(5'h04, v); chk({req, " mask"}, v, 32'(m_mask));
        chk({req, " irq R9"}, 32'(irq), 32'(|(m_status & ~m_mask)));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        m_status = '0;
        m_mask   = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_all("R1");

        // R2 command registers and holes read as zero
        rd(5'h08, v); chk("R2 rd 0x08", v, 0);
        rd(5'h0C, v); chk("R2 rd 0x0C", v, 0);
        rd(5'h10, v); chk("R2 rd 0x10", v, 0);
        rd(5'h14, v); chk("R2 rd 0x14", v, 0);
        rd(5'h1C, v); chk("R2 rd 0x1C", v, 0);

        // R4 direct mask write ignored
        op(1'b1, 5'h04, 32'h0, '0);
        check_all("R4");

        // R7 with reserved bits set (R10)
        op(1'b1, 5'h10, 32'hFFFF_FEA5, '0);
        check_all("R7 R10");
        op(1'b1, 5'h08, 32'hFFFF_FC00, '0);
        check_all("R10 enable upper bits");

        // R5 R6 walking one
        for (int i = 0; i < N; i++) begin
            op(1'b1, 5'h08, 32'(1) << i, '0);
            check_all("R5 walk");
            op(1'b1, 5'h0C, 32'(1) << i, '0);
            check_all("R6 walk");
        end

        // R3 write-one-to-clear, then writing zero keeps bits
        op(1'b1, 5'h08, 32'h3FF, '0);
        op(1'b1, 5'h00, 32'h0A1, '0);
        check_all("R3 clear");
        op(1'b1, 5'h00, 32'h0, '0);
        check_all("R3 zero write");

        // R8 event alone, then event against clear in same cycle
        op(1'b0, 5'h00, 32'h0, 10'h200);
        check_all("R8 event");
        op(1'b1, 5'h10, 32'h003, '0);
        op(1'b1, 5'h00, 32'h003, 10'h001);
        check_all("R8 set wins");
        rd(5'h00, v); chk("R8 bit0 kept", 32'(v[0]), 1);

        // R9 exhaustive enable patterns
        for (int p = 0; p < (1 << N); p++) begin
            op(1'b1, 5'h0C, 32'h3FF, '0);
            op(1'b1, 5'h00, 32'h3FF, '0);
            op(1'b1, 5'h08, 32'(p), '0);
            op(1'b1, 5'h10, 32'((p * 389 + 77) % 1024), '0);
            check_all("R9 sweep R5");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule